// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block is the software-visible side of a 64-bit block-cipher accelerator. It sits on a 32-bit memory-mapped register port. It holds the key words, a two-word chaining value, a control word, a byte count, the data window, interrupt status and enable, and a request-gating word for an external data mover. It steps the engine through one block at a time. First it asks for input. When the upper data word is written it runs the transform. It then offers the result, and a read of the upper data word releases that result.

The cipher rounds are represented by a keyed placeholder. Encryption rotates the block left by 8 bits and then XORs it with the effective key. Decryption is the exact inverse. The transform has a fixed latency set by a parameter. Around it the block applies chaining feedback in both directions, so the surrounding sequencing and register behaviour are exercised as they would be with a real cipher.

Top module: `blkc_regfront`

## Requirements
- R1: After reset every register reads 0, except the revision word at 0x30, which reads the major number in bits 10:8 and the minor number in bits 5:0. irq, dma_in_req and dma_out_req are low.
- R2: Key word n (n = 0..5) is read and written at byte address 0x14 − 4·(n XOR 1), which gives 0x10, 0x14, 0x08, 0x0C, 0x00, 0x04. Within each pair, word 2p is the low half and word 2p+1 is the high half.
- R3: In the control word at 0x20, bit 4 selects chaining, bit 3 selects triple-key and bit 2 selects encrypt; all three can be written and read back. Bit 1 (input ready) and bit 0 (output ready) are flags that can only be read; writes to them have no effect.
- R4: A write to 0x24 while the block is idle loads the remaining-byte count with bits 2:0 forced to 0. A read of 0x24 returns the remaining count. While the count is non-zero, input ready rises one cycle after the load.
- R5: Data words go to 0x28 (bits 31:0 of the block) and 0x2C (bits 63:32). A write to 0x28 alone does not start the engine. Only the write to 0x2C starts it.
- R6: Output ready rises exactly LATENCY cycles after the 0x2C write. In the non-chained mode the result is rotl8(x) XOR K for encrypt and rotr8(x XOR K) for decrypt, and it stays unchanged until it is released.
- R7: In single-key mode K = {word1, word0}. In triple-key mode K = {word1, word0} XOR {word3, word2} XOR {word5, word4}. In single-key mode words 2 to 5 have no effect.
- R8: In chained encrypt the input is XORed with the chaining value {0x1C, 0x18} before the transform, and the chaining value then becomes the output. In the non-chained mode the chaining value is never changed by the engine.
- R9: In chained decrypt the transform output is XORed with the chaining value, and the chaining value then becomes the ciphertext input.
- R10: Interrupt status at 0x3C has bit 1 (input request) and bit 2 (output available). Bit 1 is set whenever input ready rises, and bit 2 is set when output ready rises. A write keeps each bit only where the written value has a 1, so a write can never set a bit. irq is the OR of (status AND enable at 0x40).
- R11: A read of 0x2C releases the output and subtracts 8 from the remaining count. A read of 0x28 does not release it. When the count reaches zero, input ready stays low.
- R12: In the request-gating word at 0x34, bit 0 is start, bit 5 enables the input request and bit 6 enables the output request. dma_in_req = start AND bit5 AND input ready. dma_out_req = start AND bit6 AND output ready.
- R13: The revision word ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; only needed for the releasing read of 0x2C |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq | output | 1 | Interrupt: any enabled status bit set |
| dma_in_req | output | 1 | Request to the data mover to supply a block |
| dma_out_req | output | 1 | Request to the data mover to collect a block |

## Verification
The bench sweeps all eight combinations of chaining, triple-key and direction, each over two key seeds and three-block transfers. Each block value changes with the block index, so a stale data word or a swapped half shows up. Single-key runs load non-zero values into words 2 to 5, so a key word taken from the wrong address or an unwanted triple-key XOR changes the result. Chained runs compare every block and the final chaining value: encrypt tells apart feedback applied before or after the transform, and decrypt tells apart feedback from the ciphertext and from the output. Per-block checks of latency, status, irq, non-releasing reads and the zero-count stop, together with a gated-request transfer, separate the handshake ordering from the data path.

// File: rtl/blkc_pkg.sv
// Shared constants, sequencer state type and placeholder transform for the
// block-cipher register front-end. Assumes a 64-bit block on a 32-bit bus.
package blkc_pkg;
    localparam int BUS_AW    = 8;
    localparam int WORD_W    = 32;
    localparam int BLK_W     = 2 * WORD_W;
    localparam int KEY_WORDS = 6;
    localparam int XF_ROT    = 8;

    localparam logic [BUS_AW-1:0] A_KEY_TOP = 8'h14;
    localparam logic [BUS_AW-1:0] A_CV0     = 8'h18;
    localparam logic [BUS_AW-1:0] A_CV1     = 8'h1C;
    localparam logic [BUS_AW-1:0] A_CTRL    = 8'h20;
    localparam logic [BUS_AW-1:0] A_LEN     = 8'h24;
    localparam logic [BUS_AW-1:0] A_DAT0    = 8'h28;
    localparam logic [BUS_AW-1:0] A_DAT1    = 8'h2C;
    localparam logic [BUS_AW-1:0] A_REV     = 8'h30;
    localparam logic [BUS_AW-1:0] A_MASK    = 8'h34;
    localparam logic [BUS_AW-1:0] A_ISTAT   = 8'h3C;
    localparam logic [BUS_AW-1:0] A_IEN     = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_IN = 2'd1,
        ST_RUN     = 2'd2,
        ST_OUT     = 2'd3
    } seq_state_t;

    // Byte address of key word n: pairs are stored top-down, halves swapped.
    function automatic logic [BUS_AW-1:0] key_addr(input int n);
        return A_KEY_TOP - BUS_AW'((n ^ 1) * 4);
    endfunction

    // Placeholder forward transform: rotate left, then mix in the key.
    function automatic logic [BLK_W-1:0] xf_fwd(input logic [BLK_W-1:0] x,
                                                input logic [BLK_W-1:0] k);
        return {x[BLK_W-XF_ROT-1:0], x[BLK_W-1:BLK_W-XF_ROT]} ^ k;
    endfunction

    // Placeholder inverse transform: remove the key, then rotate right.
    function automatic logic [BLK_W-1:0] xf_inv(input logic [BLK_W-1:0] y,
                                                input logic [BLK_W-1:0] k);
        logic [BLK_W-1:0] t;
        t = y ^ k;
        return {t[XF_ROT-1:0], t[BLK_W-1:XF_ROT]};
    endfunction
endpackage

// File: rtl/blkc_keymix.sv
// Effective-key builder: folds the stored key pairs into one block-wide key.
// Assumes the words are packed with word n at bits [n*WW +: WW]. Pair 0 is
// always used; the further pairs are XORed in only in triple-key mode.
module blkc_keymix #(
    parameter int NWORDS = 6,
    parameter int WW     = 32
) (
    input  logic [NWORDS*WW-1:0] key_flat,
    input  logic                 triple,
    output logic [2*WW-1:0]      key_eff
);
    localparam int NPAIR = NWORDS / 2;

    logic [NPAIR-1:0][2*WW-1:0] acc;

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            logic [2*WW-1:0] pair_v;
            // Purpose: slice pair p as {word 2p+1, word 2p}.
            assign pair_v = key_flat[p*2*WW +: 2*WW];
            if (p == 0) begin : g_first
                assign acc[p] = pair_v;
            end else begin : g_rest
                assign acc[p] = acc[p-1] ^ (triple ? pair_v : '0);
            end
        end
    endgenerate

    assign key_eff = acc[NPAIR-1];
endmodule

// File: rtl/blkc_chain.sv
// Chaining datapath around the placeholder transform. It gives the block
// result and the next chaining value for the current mode. Purely
// combinational; the caller decides when to capture the results.
module blkc_chain
    import blkc_pkg::*;
(
    input  logic [BLK_W-1:0] din,
    input  logic [BLK_W-1:0] cv,
    input  logic [BLK_W-1:0] key,
    input  logic             encrypt,
    input  logic             chained,
    output logic [BLK_W-1:0] result,
    output logic [BLK_W-1:0] cv_next
);
    logic [BLK_W-1:0] fb;

    assign fb = chained ? cv : '0;

    // Purpose: feedback before the transform on encrypt, after it on decrypt.
    always_comb begin
        if (encrypt) begin
            result  = xf_fwd(din ^ fb, key);
            cv_next = result;
        end else begin
            result  = xf_inv(din, key) ^ fb;
            cv_next = din;
        end
    end
endmodule

// File: rtl/blkc_seq.sv
// Per-block sequencer: remaining-byte count, input/run/output handshake,
// fixed transform latency and the two sticky interrupt status bits.
// Assumes LAT >= 1 and LEN_W > 3. All state is cleared by a synchronous
// active-low reset.
module blkc_seq
    import blkc_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [LEN_W-4:0] len_hi,
    input  logic             din_last_wr,
    input  logic             dout_last_rd,
    input  logic             stat_wr,
    input  logic [1:0]       stat_keep,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic             run_done,
    output logic [1:0]       stat,
    output logic [LEN_W-1:0] remaining
);
    localparam int               CNT_W     = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LAT - 1);
    localparam logic [LEN_W-1:0] BLK_BYTES = LEN_W'(8);

    seq_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] rem_q;
    logic             st_in_q, st_out_q;
    logic             last_blk, set_in, set_out;

    assign in_rdy    = (st_q == ST_WAIT_IN);
    assign out_rdy   = (st_q == ST_OUT);
    assign run_done  = (st_q == ST_RUN) && (cnt_q == CNT_LAST);
    assign last_blk  = (rem_q == BLK_BYTES);
    assign set_in    = ((st_q == ST_IDLE) && (rem_q != '0)) ||
                       ((st_q == ST_OUT) && dout_last_rd && !last_blk);
    assign set_out   = run_done;
    assign stat      = {st_out_q, st_in_q};
    assign remaining = rem_q;

    // Purpose: advance the block handshake and keep the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            rem_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (len_wr) begin
                        rem_q <= {len_hi, 3'b000};
                    end else if (rem_q != '0) begin
                        st_q <= ST_WAIT_IN;
                    end
                end
                ST_WAIT_IN: begin
                    if (din_last_wr) begin
                        st_q  <= ST_RUN;
                        cnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (run_done) st_q <= ST_OUT;
                    else          cnt_q <= cnt_q + CNT_W'(1);
                end
                ST_OUT: begin
                    if (dout_last_rd) begin
                        rem_q <= rem_q - BLK_BYTES;
                        st_q  <= last_blk ? ST_IDLE : ST_WAIT_IN;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: sticky status bits; a write may only clear, events set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_in_q  <= 1'b0;
            st_out_q <= 1'b0;
        end else begin
            st_in_q  <= (stat_wr ? (st_in_q & stat_keep[0]) : st_in_q) | set_in;
            st_out_q <= (stat_wr ? (st_out_q & stat_keep[1]) : st_out_q) | set_out;
        end
    end

    assert_len_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q[2:0] == 3'b000);

    assert_wait_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy && !din_last_wr) |=> in_rdy);

    assert_out_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> st_out_q);

    assert_out_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && !dout_last_rd) |=> out_rdy);

    assert_release_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && dout_last_rd) |=> (rem_q == $past(rem_q) - BLK_BYTES));

    assert_stop_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == '0) |-> (!in_rdy && !out_rdy));
endmodule

// File: rtl/blkc_regfront.sv
// Register front-end for a 64-bit block-cipher engine on a 32-bit bus.
// It decodes the register map, holds keys, chaining value and data words,
// and drives the interrupt and data-mover request outputs. Reads are
// combinational on bus_addr; only a read of the upper data word has a side
// effect. Synchronous active-low reset clears everything except the
// constant revision word.
module blkc_regfront
    import blkc_pkg::*;
#(
    parameter int          LATENCY   = 4,
    parameter int          LEN_W     = 16,
    parameter logic [2:0]  REV_MAJOR = 3'd2,
    parameter logic [5:0]  REV_MINOR = 6'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_in_req,
    output logic              dma_out_req
);
    localparam int NKEY = KEY_WORDS;

    logic [NKEY*WORD_W-1:0] key_flat;
    logic [BLK_W-1:0]       cv_q, din_q, dout_q;
    logic                   ctrl_cbc, ctrl_tdes, ctrl_enc;
    logic                   mask_go, mask_in, mask_out;
    logic [1:0]             ien_q;
    logic [BLK_W-1:0]       key_eff, result, cv_next;
    logic                   in_rdy, out_rdy, run_done;
    logic [1:0]             stat;
    logic [LEN_W-1:0]       remaining;
    logic                   wr_cv0, wr_cv1;

    assign wr_cv0 = bus_wr && (bus_addr == A_CV0);
    assign wr_cv1 = bus_wr && (bus_addr == A_CV1);

    blkc_keymix #(.NWORDS(NKEY), .WW(WORD_W)) u_keymix (
        .key_flat (key_flat),
        .triple   (ctrl_tdes),
        .key_eff  (key_eff)
    );

    blkc_chain u_chain (
        .din     (din_q),
        .cv      (cv_q),
        .key     (key_eff),
        .encrypt (ctrl_enc),
        .chained (ctrl_cbc),
        .result  (result),
        .cv_next (cv_next)
    );

    blkc_seq #(.LAT(LATENCY), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .len_wr       (bus_wr && (bus_addr == A_LEN)),
        .len_hi       (bus_wdata[LEN_W-1:3]),
        .din_last_wr  (bus_wr && (bus_addr == A_DAT1)),
        .dout_last_rd (bus_rd && (bus_addr == A_DAT1)),
        .stat_wr      (bus_wr && (bus_addr == A_ISTAT)),
        .stat_keep    (bus_wdata[2:1]),
        .in_rdy       (in_rdy),
        .out_rdy      (out_rdy),
        .run_done     (run_done),
        .stat         (stat),
        .remaining    (remaining)
    );

    // Purpose: register writes, and result/chaining capture at block end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_flat  <= '0;
            cv_q      <= '0;
            din_q     <= '0;
            dout_q    <= '0;
            ctrl_cbc  <= 1'b0;
            ctrl_tdes <= 1'b0;
            ctrl_enc  <= 1'b0;
            mask_go   <= 1'b0;
            mask_in   <= 1'b0;
            mask_out  <= 1'b0;
            ien_q     <= '0;
        end else begin
            if (bus_wr) begin
                for (int n = 0; n < NKEY; n++) begin
                    if (bus_addr == key_addr(n)) key_flat[n*WORD_W +: WORD_W] <= bus_wdata;
                end
                case (bus_addr)
                    A_CV0:  cv_q[WORD_W-1:0]     <= bus_wdata;
                    A_CV1:  cv_q[BLK_W-1:WORD_W] <= bus_wdata;
                    A_CTRL: {ctrl_cbc, ctrl_tdes, ctrl_enc} <= bus_wdata[4:2];
                    A_DAT0: if (in_rdy) din_q[WORD_W-1:0]     <= bus_wdata;
                    A_DAT1: if (in_rdy) din_q[BLK_W-1:WORD_W] <= bus_wdata;
                    A_MASK: {mask_out, mask_in, mask_go} <= {bus_wdata[6], bus_wdata[5], bus_wdata[0]};
                    A_IEN:  ien_q <= bus_wdata[2:1];
                    default: ;
                endcase
            end
            if (run_done) begin
                dout_q <= result;
                if (ctrl_cbc) cv_q <= cv_next;
            end
        end
    end

    // Purpose: combinational read mux over the register map.
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NKEY; n++) begin
            if (bus_addr == key_addr(n)) bus_rdata = key_flat[n*WORD_W +: WORD_W];
        end
        case (bus_addr)
            A_CV0:   bus_rdata = cv_q[WORD_W-1:0];
            A_CV1:   bus_rdata = cv_q[BLK_W-1:WORD_W];
            A_CTRL:  bus_rdata = {27'd0, ctrl_cbc, ctrl_tdes, ctrl_enc, in_rdy, out_rdy};
            A_LEN:   bus_rdata = WORD_W'(remaining);
            A_DAT0:  bus_rdata = dout_q[WORD_W-1:0];
            A_DAT1:  bus_rdata = dout_q[BLK_W-1:WORD_W];
            A_REV:   bus_rdata = {21'd0, REV_MAJOR, 2'b00, REV_MINOR};
            A_MASK:  bus_rdata = {25'd0, mask_out, mask_in, 4'd0, mask_go};
            A_ISTAT: bus_rdata = {29'd0, stat, 1'b0};
            A_IEN:   bus_rdata = {29'd0, ien_q, 1'b0};
            default: ;
        endcase
    end

    assign irq         = |(stat & ien_q);
    assign dma_in_req  = mask_go && mask_in && in_rdy;
    assign dma_out_req = mask_go && mask_out && out_rdy;

    assert_dout_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy && $past(out_rdy)) |-> $stable(dout_q));

    assert_cv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_cbc && !wr_cv0 && !wr_cv1) |=> $stable(cv_q));

    assert_req_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_in_req && dma_out_req));

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(in_rdy) || $rose(out_rdy) || $changed(ien_q)));
endmodule

// File: tb/test_blkc_regfront.sv
`timescale 1ns/1ps
module test_blkc_regfront;
    localparam int          LAT     = 4;
    localparam logic [31:0] REV_EXP = 32'h0000_0209;
    localparam logic [7:0]  CV0 = 8'h18, CV1 = 8'h1C, CTRL = 8'h20, LEN = 8'h24;
    localparam logic [7:0]  D0 = 8'h28, D1 = 8'h2C, REV = 8'h30, MSK = 8'h34;
    localparam logic [7:0]  IST = 8'h3C, IEN = 8'h40;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, dma_in_req, dma_out_req;
    int          n_cmp = 0, n_bad = 0, cyc = 0;
    bit          done = 1'b0;
    logic [31:0] kw [6];

    always #5 clk = ~clk;

    blkc_regfront #(.LATENCY(LAT), .LEN_W(16), .REV_MAJOR(3'd2), .REV_MINOR(6'd9)) i_blkc_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] kaddr(input int n);
        return 8'h14 - 8'(4 * (n ^ 1));
    endfunction

    function automatic logic [63:0] eff_key(input bit tdes);
        logic [63:0] k;
        k = {kw[1], kw[0]};
        if (tdes) k = k ^ {kw[3], kw[2]} ^ {kw[5], kw[4]};
        return k;
    endfunction

    function automatic logic [63:0] ref_fwd(input logic [63:0] x, input logic [63:0] k);
        return {x[55:0], x[63:56]} ^ k;
    endfunction

    function automatic logic [63:0] ref_inv(input logic [63:0] y, input logic [63:0] k);
        logic [63:0] t;
        t = y ^ k;
        return {t[7:0], t[63:8]};
    endfunction

    task automatic wait_in(input string req);
        logic [31:0] v;
        int k = 0;
        @(negedge clk); peek(CTRL, v);
        while (!v[1] && k < 60) begin @(negedge clk); peek(CTRL, v); k++; end
        check(req, 64'(v[1]), 64'd1);
    endtask

    task automatic run_xfer(input bit cbc, input bit tdes, input bit enc,
                            input int nblk, input logic [31:0] seed);
        logic [31:0] v, v0, v1;
        logic [63:0] cv, pt, ex, k;
        string tg;
        int lat;
        tg = cbc ? (enc ? "R8 R7" : "R9 R7") : "R6 R7";
        for (int n = 0; n < 6; n++) begin
            kw[n] = (seed * 32'(n + 3)) ^ (32'h1111_1111 << n);
            wr(kaddr(n), kw[n]);
        end
        for (int n = 0; n < 6; n++) begin
            rd(kaddr(n), v);
            check("R2 key readback", 64'(v), 64'(kw[n]));
        end
        k  = eff_key(tdes);
        cv = {seed ^ 32'h1357_9BDF, seed ^ 32'h2468_ACE0};
        wr(CV0, cv[31:0]); wr(CV1, cv[63:32]);
        wr(CTRL, {27'd0, cbc, tdes, enc, 2'b11});
        wr(IEN, 32'h6);
        wr(LEN, 32'(nblk * 8 + 5));
        rd(LEN, v);
        check("R4 length aligned", 64'(v), 64'(nblk * 8));
        for (int b = 0; b < nblk; b++) begin
            wait_in("R4 input ready");
            rd(IST, v);
            check("R10 input status", 64'(v), 64'h2);
            check("R10 irq set", 64'(irq), 64'd1);
            wr(IST, 32'h4);
            peek(IST, v);
            check("R10 status cleared", 64'(v), 64'h0);
            check("R10 irq cleared", 64'(irq), 64'd0);
            pt = {seed + 32'(b * 32'h0101_0101), ~seed ^ 32'(b * 32'h3C00_00A5)};
            wr(D0, pt[31:0]);
            if (b == 0) begin
                repeat (2 * LAT) @(negedge clk);
                peek(CTRL, v);
                check("R5 low word alone", 64'(v[1:0]), 64'h2);
            end
            wr(D1, pt[63:32]);
            lat = 0;
            peek(CTRL, v);
            while (!v[0] && lat < 100) begin lat++; @(negedge clk); peek(CTRL, v); end
            check("R6 latency", 64'(lat), 64'(LAT));
            if (enc) begin
                ex = ref_fwd(cbc ? (pt ^ cv) : pt, k);
                if (cbc) cv = ex;
            end else begin
                ex = ref_inv(pt, k) ^ (cbc ? cv : 64'd0);
                if (cbc) cv = pt;
            end
            peek(IST, v);
            check("R10 output status", 64'(v), 64'h4);
            rd(D0, v0);
            rd(D0, v0);
            peek(CTRL, v);
            check("R11 low read keeps output", 64'(v[0]), 64'd1);
            rd(D1, v1);
            check(tg, {v1, v0}, ex);
            wr(IST, 32'h2);
        end
        repeat (6) @(negedge clk);
        peek(CTRL, v);
        check("R11 stop at zero", 64'(v[1:0]), 64'h0);
        rd(LEN, v);
        check("R11 count zero", 64'(v), 64'h0);
        peek(IST, v);
        check("R10 final status", 64'(v), 64'h0);
        check("R10 final irq", 64'(irq), 64'd0);
        rd(CV0, v0); rd(CV1, v1);
        check(cbc ? (enc ? "R8 chain value" : "R9 chain value") : "R8 chain untouched",
              {v1, v0}, cv);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=%0d exp=below 150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values across the whole map
        for (int a = 0; a <= 8'h40; a += 4) begin
            peek(8'(a), v);
            check("R1 reset value", 64'(v), (a == 8'h30) ? 64'(REV_EXP) : 64'h0);
        end
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 requests", {62'd0, dma_in_req, dma_out_req}, 64'd0);
        // R13: revision ignores writes
        wr(REV, 32'h0);
        peek(REV, v);
        check("R13 revision", 64'(v), 64'(REV_EXP));
        // R3: control bits, flags read-only
        wr(CTRL, 32'hFFFF_FFFF);
        peek(CTRL, v);
        check("R3 control", 64'(v), 64'h1C);
        wr(CTRL, 32'h0);
        // R10: a write can never set status
        wr(IST, 32'hFFFF_FFFF);
        peek(IST, v);
        check("R10 no set by write", 64'(v), 64'h0);
        // Sweep of every mode under two seeds
        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 8; m++)
                run_xfer(m[2], m[1], m[0], 3, 32'hC0DE_0000 + 32'(s * 32'h0BAD_F00D) + 32'(m));
        // R12: gated data-mover requests
        wr(CTRL, 32'h4);
        wr(MSK, 32'h61);
        wr(LEN, 32'd8);
        wait_in("R12 input ready");
        check("R12 in request", {62'd0, dma_in_req, dma_out_req}, 64'h2);
        wr(D0, 32'h1234_5678);
        wr(D1, 32'h9ABC_DEF0);
        repeat (LAT + 2) @(negedge clk);
        check("R12 out request", {62'd0, dma_in_req, dma_out_req}, 64'h1);
        wr(MSK, 32'h60);
        check("R12 start gate", {62'd0, dma_in_req, dma_out_req}, 64'h0);
        rd(D1, v);
        wr(IST, 32'h0);
        repeat (4) @(negedge clk);
        check("R11 done after one block", {62'd0, dma_in_req, irq}, 64'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule